// File: doc/BRIEF.md
# E1 Time Slot 16 and Remote Alarm Integrator

This block sits behind an E1 receive framer that has already found frame and multiframe alignment. Once per frame it takes the time slot 16 octet together with that frame's position inside the 16-frame signaling multiframe. It also takes the A bit (bit 3) of each frame that does not carry the alignment word, which the framer presents with its own strobe. From these inputs it derives four persistent alarm levels: time slot 16 carrying almost only ones, time slot 16 carrying only zeros, the far end reporting loss of multiframe alignment, and the far end reporting a remote alarm.

The signaling alarms are judged over whole multiframes, and all of them are decided from a zero count. The distant multiframe alarm and the remote alarm pass through run-length filters. These filters need the same value several times in a row before the level changes, in either direction. When multiframe alignment is lost, the partial multiframe and the distant-alarm run counts are dropped, and the alarm levels already reported stay as they are. Bits are numbered the E1 way: bit 1 is the first bit sent and is the MSB of the octet, so bit 6 sits at octet position [2].

Top module: `e1_alarm_integ`

## Requirements
- R1: At the end of a complete multiframe in which time slot 16 holds fewer than 3 zero bits in total (counted over all 16 octets), sig_all_ones goes high.
- R2: At the end of a complete multiframe in which time slot 16 holds 3 or more zero bits, sig_all_ones goes low.
- R3: At the end of a complete multiframe, sig_all_zeros goes high if all 128 bits of time slot 16 were zero, and goes low if at least one bit was one. sig_all_ones and sig_all_zeros are never high together.
- R4: Each complete multiframe contributes one sample to the distant multiframe filter: bit 6 (ts16_octet[2]) of its frame-0 octet. dist_mf_alarm goes high after 2 consecutive samples of one and goes low after 2 consecutive samples of zero.
- R5: remote_alarm goes high after nafr_bit3 has been 1 on 3 consecutive nafr_valid strobes, and goes low after it has been 0 on 3 consecutive strobes. It changes only in the cycle after a strobe.
- R6: In both run filters, a sample of the opposite value restarts the run count. Runs interrupted by an opposite sample never change the level.
- R7: A multiframe counts as complete only when it opens with ts16_valid and mf_start together and then supplies frame numbers 1 to 15 in order. The three multiframe alarms change only in the cycle after the frame-15 octet of a complete multiframe. A broken or unstarted sequence leaves them unchanged.
- R8: A cycle with mf_lost high discards the multiframe in progress and clears the distant-alarm run counts. The alarm levels keep their values.
- R9: While rst is high, and in the first cycle after, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts16_valid | input | 1 | Time slot 16 octet present this cycle |
| mf_start | input | 1 | With ts16_valid, marks frame 0 of a multiframe |
| ts16_frame | input | $clog2(MF_LEN) | Frame number of the octet within the multiframe |
| ts16_octet | input | 8 | Time slot 16 content, bit 1 at [7] |
| mf_lost | input | 1 | Loss of multiframe alignment |
| nafr_valid | input | 1 | Non-align frame A bit present this cycle |
| nafr_bit3 | input | 1 | Bit 3 of the non-align frame |
| sig_all_ones | output | 1 | Signaling all-ones alarm |
| sig_all_zeros | output | 1 | Signaling all-zeros alarm |
| dist_mf_alarm | output | 1 | Distant multiframe alarm |
| remote_alarm | output | 1 | Remote alarm |

## Verification
The assertions check on every cycle that the multiframe alarms move only in the cycle after a frame-15 octet and never in the cycle after mf_lost. They also check that the two signaling alarms are never high together, that remote_alarm moves only after a strobe and in the direction of the bit sampled, and that reset clears every output. Only the bench's scenarios can show the thresholds themselves: the 2-zero versus 3-zero boundary, the exact run lengths and run restarts, that the distant alarm reads the bit at octet position [2], and that broken or interrupted multiframes are thrown away.

// File: rtl/e1_alarm_pkg.sv
package e1_alarm_pkg;

  localparam int OCTET_W     = 8;
  // Bit 6 in first-sent-is-bit-1 numbering lives at octet index 2.
  localparam int TS16_B6_POS = 2;

  function automatic logic [3:0] zero_bits8(input logic [OCTET_W-1:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < OCTET_W; i++) begin
      if (!v[i]) n = n + 4'd1;
    end
    return n;
  endfunction

endpackage

// File: rtl/e1_run_filter.sv
// Symmetric run-length filter: the level follows the sample once the
// same value has been seen on a required number of consecutive strobes.
module e1_run_filter #(
  parameter int SET_RUN = 2,
  parameter int CLR_RUN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic strobe,
  input  logic sample,
  output logic level
);

  localparam int RUN_MAX = (SET_RUN > CLR_RUN) ? SET_RUN : CLR_RUN;
  localparam int CW      = $clog2(RUN_MAX + 1);

  logic [CW-1:0] ones_run;
  logic [CW-1:0] zeros_run;
  logic [CW:0]   ones_nxt;
  logic [CW:0]   zeros_nxt;

  always_comb begin
    ones_nxt  = {1'b0, ones_run}  + (CW+1)'(1);
    zeros_nxt = {1'b0, zeros_run} + (CW+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_run  <= '0;
      zeros_run <= '0;
      level     <= 1'b0;
    end else if (flush) begin
      ones_run  <= '0;
      zeros_run <= '0;
    end else if (strobe) begin
      if (sample) begin
        zeros_run <= '0;
        if (ones_nxt <= (CW+1)'(RUN_MAX)) ones_run <= ones_nxt[CW-1:0];
        if (ones_nxt >= (CW+1)'(SET_RUN)) level <= 1'b1;
      end else begin
        ones_run <= '0;
        if (zeros_nxt <= (CW+1)'(RUN_MAX)) zeros_run <= zeros_nxt[CW-1:0];
        if (zeros_nxt >= (CW+1)'(CLR_RUN)) level <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/e1_ts16_accum.sv
// Follows one signaling multiframe of time slot 16 octets, sums their
// zero bits and flags the final octet of a complete, in-order multiframe.
module e1_ts16_accum
  import e1_alarm_pkg::*;
#(
  parameter int MF_LEN = 16,
  localparam int FW = $clog2(MF_LEN),
  localparam int ZW = $clog2(MF_LEN * OCTET_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               valid,
  input  logic               start,
  input  logic [FW-1:0]      frame,
  input  logic [OCTET_W-1:0] octet,
  output logic               mf_end,
  output logic [ZW-1:0]      mf_zeros,
  output logic               f0_bit6
);

  localparam logic [FW-1:0] LAST = FW'(MF_LEN - 1);
  localparam logic [FW-1:0] PEN  = FW'(MF_LEN - 2);

  logic          active;
  logic [FW-1:0] idx;
  logic [ZW-1:0] zsum;
  logic [3:0]    oct_zeros;

  always_comb begin
    oct_zeros = zero_bits8(octet);
    mf_zeros  = zsum + ZW'(oct_zeros);
    mf_end    = valid && !flush && !start && active &&
                (frame == LAST) && (idx == PEN);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      active <= 1'b0;
      idx    <= '0;
      zsum   <= '0;
    end else if (valid) begin
      if (start) begin
        active <= 1'b1;
        idx    <= '0;
        zsum   <= ZW'(oct_zeros);
      end else if (active) begin
        if (mf_end) begin
          active <= 1'b0;
        end else if (frame == idx + FW'(1)) begin
          idx  <= frame;
          zsum <= mf_zeros;
        end else begin
          active <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f0_bit6 <= 1'b0;
    end else if (valid && start && !flush) begin
      f0_bit6 <= octet[TS16_B6_POS];
    end
  end

endmodule

// File: rtl/e1_alarm_integ.sv
module e1_alarm_integ
  import e1_alarm_pkg::*;
#(
  parameter int MF_LEN       = 16,
  parameter int AIS_ZERO_LIM = 3,
  parameter int DMA_RUN      = 2,
  parameter int RA_RUN       = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ts16_valid,
  input  logic                      mf_start,
  input  logic [$clog2(MF_LEN)-1:0] ts16_frame,
  input  logic [7:0]                ts16_octet,
  input  logic                      mf_lost,
  input  logic                      nafr_valid,
  input  logic                      nafr_bit3,
  output logic                      sig_all_ones,
  output logic                      sig_all_zeros,
  output logic                      dist_mf_alarm,
  output logic                      remote_alarm
);

  localparam int MF_BITS = MF_LEN * OCTET_W;
  localparam int ZW      = $clog2(MF_BITS + 1);

  logic          mf_end;
  logic [ZW-1:0] mf_zeros;
  logic          f0_bit6;

  e1_ts16_accum #(.MF_LEN(MF_LEN)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .flush    (mf_lost),
    .valid    (ts16_valid),
    .start    (mf_start),
    .frame    (ts16_frame),
    .octet    (ts16_octet),
    .mf_end   (mf_end),
    .mf_zeros (mf_zeros),
    .f0_bit6  (f0_bit6)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_all_ones  <= 1'b0;
      sig_all_zeros <= 1'b0;
    end else if (mf_end) begin
      sig_all_ones  <= (mf_zeros < ZW'(AIS_ZERO_LIM));
      sig_all_zeros <= (mf_zeros == ZW'(MF_BITS));
    end
  end

  e1_run_filter #(.SET_RUN(DMA_RUN), .CLR_RUN(DMA_RUN)) u_dma_filt (
    .clk    (clk),
    .rst    (rst),
    .flush  (mf_lost),
    .strobe (mf_end),
    .sample (f0_bit6),
    .level  (dist_mf_alarm)
  );

  e1_run_filter #(.SET_RUN(RA_RUN), .CLR_RUN(RA_RUN)) u_ra_filt (
    .clk    (clk),
    .rst    (rst),
    .flush  (1'b0),
    .strobe (nafr_valid),
    .sample (nafr_bit3),
    .level  (remote_alarm)
  );

endmodule

// File: rtl/e1_alarm_integ_chk.sv
module e1_alarm_integ_chk #(
  parameter int MF_LEN = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      ts16_valid,
  input logic [$clog2(MF_LEN)-1:0] ts16_frame,
  input logic                      mf_lost,
  input logic                      nafr_valid,
  input logic                      nafr_bit3,
  input logic                      sig_all_ones,
  input logic                      sig_all_zeros,
  input logic                      dist_mf_alarm,
  input logic                      remote_alarm
);

  localparam logic [$clog2(MF_LEN)-1:0] LAST = ($clog2(MF_LEN))'(MF_LEN - 1);

  a_r9_reset_idle: assert property (@(posedge clk)
    rst |=> !(sig_all_ones || sig_all_zeros || dist_mf_alarm || remote_alarm));

  a_r7_mf_alarms_hold: assert property (@(posedge clk) disable iff (rst)
    !(ts16_valid && ts16_frame == LAST) |=>
      $stable(sig_all_ones) && $stable(sig_all_zeros) && $stable(dist_mf_alarm));

  a_r8_lost_holds_levels: assert property (@(posedge clk) disable iff (rst)
    mf_lost |=>
      $stable(sig_all_ones) && $stable(sig_all_zeros) && $stable(dist_mf_alarm));

  a_r3_sig_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(sig_all_ones && sig_all_zeros));

  a_r5_ra_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    !nafr_valid |=> $stable(remote_alarm));

  a_r5_ra_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(remote_alarm) |-> $past(nafr_bit3));

  a_r5_ra_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(remote_alarm) |-> !$past(nafr_bit3));

  a_r4_dma_needs_mf_end: assert property (@(posedge clk) disable iff (rst)
    $rose(dist_mf_alarm) |-> $past(ts16_valid));

endmodule

bind e1_alarm_integ e1_alarm_integ_chk #(.MF_LEN(MF_LEN)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .ts16_valid    (ts16_valid),
  .ts16_frame    (ts16_frame),
  .mf_lost       (mf_lost),
  .nafr_valid    (nafr_valid),
  .nafr_bit3     (nafr_bit3),
  .sig_all_ones  (sig_all_ones),
  .sig_all_zeros (sig_all_zeros),
  .dist_mf_alarm (dist_mf_alarm),
  .remote_alarm  (remote_alarm)
);

// File: tb/test_e1_alarm_integ.sv
`timescale 1ns/1ps
module test_e1_alarm_integ;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ts16_valid = 1'b0;
  logic       mf_start = 1'b0;
  logic [3:0] ts16_frame = '0;
  logic [7:0] ts16_octet = '0;
  logic       mf_lost = 1'b0;
  logic       nafr_valid = 1'b0;
  logic       nafr_bit3 = 1'b0;
  logic       sig_all_ones, sig_all_zeros, dist_mf_alarm, remote_alarm;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  e1_alarm_integ i_e1_alarm_integ (
    .clk(clk), .rst(rst), .ts16_valid(ts16_valid), .mf_start(mf_start),
    .ts16_frame(ts16_frame), .ts16_octet(ts16_octet), .mf_lost(mf_lost),
    .nafr_valid(nafr_valid), .nafr_bit3(nafr_bit3),
    .sig_all_ones(sig_all_ones), .sig_all_zeros(sig_all_zeros),
    .dist_mf_alarm(dist_mf_alarm), .remote_alarm(remote_alarm)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ts16_valid = 1'b0; mf_start = 1'b0; nafr_valid = 1'b0; mf_lost = 1'b0;
  endtask

  task automatic put_octet(input int fr, input logic [7:0] oct, input logic st);
    @(negedge clk);
    ts16_valid = 1'b1; mf_start = st; ts16_frame = 4'(fr); ts16_octet = oct;
    nafr_valid = 1'b0; mf_lost = 1'b0;
  endtask

  // Full multiframe: frame 0 = f0, frames 1..14 = mid, frame 15 = lst.
  task automatic send_mf(input logic [7:0] f0, input logic [7:0] mid, input logic [7:0] lst);
    put_octet(0, f0, 1'b1);
    for (int f = 1; f < 15; f++) put_octet(f, mid, 1'b0);
    put_octet(15, lst, 1'b0);
    idle();
  endtask

  task automatic send_ra(input logic b);
    @(negedge clk);
    nafr_valid = 1'b1; nafr_bit3 = b;
    idle();
  endtask

  task automatic t_reset();
    check(sig_all_ones,  1'b0, "R9", "all-ones after reset");
    check(sig_all_zeros, 1'b0, "R9", "all-zeros after reset");
    check(dist_mf_alarm, 1'b0, "R9", "distant MF after reset");
    check(remote_alarm,  1'b0, "R9", "remote after reset");
  endtask

  task automatic t_all_ones();
    send_mf(8'hFB, 8'hFF, 8'hFF);   // 1 zero
    check(sig_all_ones, 1'b1, "R1", "1 zero sets");
    check(sig_all_zeros, 1'b0, "R3", "not all zeros");
    send_mf(8'hFB, 8'hFF, 8'hFE);   // 2 zeros
    check(sig_all_ones, 1'b1, "R1", "2 zeros keeps set");
    send_mf(8'hFB, 8'hFF, 8'hFC);   // 3 zeros
    check(sig_all_ones, 1'b0, "R2", "3 zeros clears");
    check(dist_mf_alarm, 1'b0, "R4", "bit6 zero keeps distant low");
  endtask

  task automatic t_all_zeros();
    send_mf(8'h00, 8'h00, 8'h00);
    check(sig_all_zeros, 1'b1, "R3", "all zeros sets");
    check(sig_all_ones, 1'b0, "R3", "all-ones low with all zeros");
    send_mf(8'h00, 8'h00, 8'h01);
    check(sig_all_zeros, 1'b0, "R3", "single one clears");
  endtask

  task automatic t_dma();
    send_mf(8'h04, 8'h55, 8'h55);
    check(dist_mf_alarm, 1'b0, "R4", "one bit6 sample not enough");
    send_mf(8'h04, 8'h55, 8'h55);
    check(dist_mf_alarm, 1'b1, "R4", "two bit6 samples set");
    send_mf(8'hFB, 8'h55, 8'h55);
    check(dist_mf_alarm, 1'b1, "R6", "single zero keeps set");
    send_mf(8'h04, 8'h55, 8'h55);
    send_mf(8'hFB, 8'h55, 8'h55);
    check(dist_mf_alarm, 1'b1, "R6", "interrupted zero run keeps set");
    send_mf(8'hFB, 8'h55, 8'h55);
    check(dist_mf_alarm, 1'b0, "R4", "two zeros at octet[2] clear");
    send_mf(8'h04, 8'h55, 8'h55);
    send_mf(8'h00, 8'h55, 8'h55);
    send_mf(8'h04, 8'h55, 8'h55);
    check(dist_mf_alarm, 1'b0, "R6", "interrupted one run stays low");
    send_mf(8'h04, 8'h55, 8'h55);
    check(dist_mf_alarm, 1'b1, "R4", "fresh run of two sets");
    send_mf(8'h00, 8'h55, 8'h55);
    send_mf(8'h00, 8'h55, 8'h55);
    check(dist_mf_alarm, 1'b0, "R4", "cleared again");
  endtask

  task automatic t_ra();
    send_ra(1'b1); send_ra(1'b1);
    check(remote_alarm, 1'b0, "R5", "two ones not enough");
    send_ra(1'b0); send_ra(1'b1); send_ra(1'b1);
    check(remote_alarm, 1'b0, "R6", "run restarted by zero");
    send_ra(1'b1);
    check(remote_alarm, 1'b1, "R5", "three ones set");
    send_ra(1'b0); send_ra(1'b0); send_ra(1'b1);
    check(remote_alarm, 1'b1, "R6", "zero run restarted by one");
    send_ra(1'b0); send_ra(1'b0);
    check(remote_alarm, 1'b1, "R5", "two zeros not enough");
    send_ra(1'b0);
    check(remote_alarm, 1'b0, "R5", "three zeros clear");
  endtask

  task automatic t_partial();
    for (int f = 3; f < 16; f++) put_octet(f, 8'h00, 1'b0);
    idle();
    check(sig_all_zeros, 1'b0, "R7", "unstarted MF ignored");
    put_octet(0, 8'h00, 1'b1);
    for (int f = 1; f < 16; f++) if (f != 5) put_octet(f, 8'h00, 1'b0);
    idle();
    check(sig_all_zeros, 1'b0, "R7", "gap in frame numbers ignored");
    send_mf(8'h00, 8'h00, 8'h00);
    check(sig_all_zeros, 1'b1, "R7", "complete MF evaluated");
  endtask

  task automatic t_lost();
    send_mf(8'h04, 8'h55, 8'h55);
    check(sig_all_zeros, 1'b0, "R3", "ones present clear all zeros");
    @(negedge clk); mf_lost = 1'b1;
    idle();
    send_mf(8'h04, 8'h55, 8'h55);
    check(dist_mf_alarm, 1'b0, "R8", "run count cleared by loss");
    send_mf(8'h04, 8'h55, 8'h55);
    check(dist_mf_alarm, 1'b1, "R8", "sets after two fresh samples");
    @(negedge clk); mf_lost = 1'b1;
    idle();
    check(dist_mf_alarm, 1'b1, "R8", "level held across loss");
    put_octet(0, 8'h00, 1'b1);
    for (int f = 1; f < 8; f++) put_octet(f, 8'h00, 1'b0);
    @(negedge clk); ts16_valid = 1'b0; mf_lost = 1'b1;
    for (int f = 8; f < 16; f++) put_octet(f, 8'h00, 1'b0);
    idle();
    check(sig_all_zeros, 1'b0, "R8", "MF interrupted by loss discarded");
    check(dist_mf_alarm, 1'b1, "R8", "distant alarm unchanged");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_all_ones();
    t_all_zeros();
    t_dma();
    t_ra();
    t_partial();
    t_lost();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule